// File: doc/BRIEF.md
# Sleep Duration and Entry Latency Counters

This block times a low-power episode from the fast host clock domain. A coarse count of slow-clock periods starts again from zero each time the processor raises its deep-sleep indication. A fine count of fast-clock cycles starts again on every slow-clock rising edge. Together the two give a sleep duration with sub-slow-period resolution. When software reads the coarse count, the fine count is captured in the same cycle. A later read of the fine value then returns the offset that belongs to that coarse value, so the pair is coherent.

A third counter measures entry latency. It counts fast cycles from the rising edge of the deep-sleep indication until the power-down sequence signals that it has started, and then it freezes. The slow clock arrives as an asynchronous level. A synchroniser chain and an edge detector in the fast domain turn it into a one-cycle tick. All three values are read-only and are read through a simple registered read port.

Top module: `sleep_timer_pair`

## Requirements
- R1: After a synchronous active-low reset, every readable value is 0 and `rd_data` is 0.
- R2: The coarse count (select 0) increments by one for each rising edge of `slow_clk_in`. The edge takes effect on the second fast edge after the fast edge that first samples the new high level. The count wraps at 32 bits.
- R3: A rising edge of `sleep_deep`, sampled on the fast clock, sets the coarse count to 0. This has priority over a slow tick in the same cycle.
- R4: The live fine count is 0 in the cycle after a slow tick. It then increments once per fast cycle.
- R5: The fine count saturates at 2047 and does not wrap.
- R6: A read with select 0 captures the live fine count into the held fine value. A read with select 1 returns the held value. The held value does not change until the next select-0 read.
- R7: A rising edge of `sleep_deep` clears the entry count and starts it. The count then increments every fast cycle until a cycle with `pd_start` high. From that cycle on it holds, and the `pd_start` cycle itself does not count.
- R8: The entry count saturates at 65535.
- R9: A read with `rd_en` high returns the selected value on `rd_data` one fast cycle later. Selects are 0 coarse, 1 held fine, 2 entry, and 3 reads as 0. While `rd_en` is low, `rd_data` holds its value.
- R10: `pd_start` has no effect on any value while no entry measurement is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast host clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_clk_in | input | 1 | Slow clock, asynchronous to clk |
| sleep_deep | input | 1 | Deep-sleep indication from the processor, synchronous to clk |
| pd_start | input | 1 | Strobe marking the start of the power-down sequence |
| rd_en | input | 1 | Read request |
| rd_sel | input | 2 | Read select: 0 coarse, 1 held fine, 2 entry, 3 zero |
| rd_data | output | 32 | Registered read data, zero-extended |

## Verification
A slow rising edge reaches the coarse and fine counters on the second fast edge after the edge that first samples it. A sleep-deep rise or a `pd_start` affects the counters on the next fast edge. Read data appears one fast edge after the request. The bench model applies these same delays to its own per-cycle state, in a separate queue of past slow samples. It compares `rd_data` after every rising edge, sampled on the falling edge. The reads are placed right after sleep entry, right after a slow edge, and after long idle stretches that force both saturations, so each delay and limit is compared at the exact cycle it applies.

// File: rtl/sdm_pkg.sv
// Shared definitions for the sleep duration counters.
// Assumes a 2-bit read select on the register port.
package sdm_pkg;
    typedef enum logic [1:0] {
        SEL_COARSE = 2'd0,
        SEL_FINE   = 2'd1,
        SEL_ENTRY  = 2'd2,
        SEL_NONE   = 2'd3
    } sdm_sel_e;
endpackage

// File: rtl/sdm_edge_sync.sv
// Brings an asynchronous level into the clk domain through STAGES flops.
// Emits a one-cycle pulse on each synchronised rising edge.
// Assumes the input stays high and low for longer than STAGES+1 clk cycles.
module sdm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain;

    // Shift the sampled level through the synchroniser and the history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[CHAIN_W-2:0], async_in};
    end

    // Rising edge: the newest synchronised sample is high, the one before it low.
    assign rise_pulse = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/sdm_coarse_fine.sv
// Coarse counter of slow ticks and fine counter of fast cycles since the last tick.
// Also holds a snapshot of the fine count taken when the coarse value is read.
// Assumes tick is a single-cycle pulse in the clk domain.
module sdm_coarse_fine #(
    parameter int SLOW_W = 32,
    parameter int FINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              restart,
    input  logic              snap,
    output logic [SLOW_W-1:0] coarse,
    output logic [FINE_W-1:0] fine_live,
    output logic [FINE_W-1:0] fine_held
);
    localparam logic [FINE_W-1:0] FINE_MAX = {FINE_W{1'b1}};

    // Coarse count: a new sleep entry clears it, a slow tick advances it.
    always_ff @(posedge clk) begin
        if (!rst_n)       coarse <= '0;
        else if (restart) coarse <= '0;
        else if (tick)    coarse <= coarse + 1'b1;
    end

    // Fine count: every slow tick restarts it, and it stops at its ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n)                     fine_live <= '0;
        else if (tick)                  fine_live <= '0;
        else if (fine_live != FINE_MAX) fine_live <= fine_live + 1'b1;
    end

    // Snapshot: capture the fine count in the same cycle the coarse value is read.
    always_ff @(posedge clk) begin
        if (!rst_n)    fine_held <= '0;
        else if (snap) fine_held <= fine_live;
    end
endmodule

// File: rtl/sdm_entry_lat.sv
// Counts clk cycles from a start pulse until a stop strobe, then freezes.
// A new start restarts the count. The counter stops at its ceiling.
// Assumes start is a single-cycle pulse.
module sdm_entry_lat #(
    parameter int ENTRY_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               stop,
    output logic [ENTRY_W-1:0] count,
    output logic               busy
);
    localparam logic [ENTRY_W-1:0] ENTRY_MAX = {ENTRY_W{1'b1}};

    // Measurement flag: set by start, cleared by stop. Start wins when both are high.
    always_ff @(posedge clk) begin
        if (!rst_n)     busy <= 1'b0;
        else if (start) busy <= 1'b1;
        else if (stop)  busy <= 1'b0;
    end

    // Latency count: cleared on start, advanced while busy and not stopping, then held.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (start)
            count <= '0;
        else if (busy && !stop && count != ENTRY_MAX)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/sleep_timer_pair.sv
// Top level of the sleep duration counters.
// Measures sleep time as a coarse slow-clock count plus a fine fast-clock offset,
// and measures the latency from the deep-sleep rise to the start of power-down.
// Assumes sleep_deep and pd_start are synchronous to clk. slow_clk_in may be asynchronous.
module sleep_timer_pair #(
    parameter int SLOW_W      = 32,
    parameter int FINE_W      = 11,
    parameter int ENTRY_W     = 16,
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_clk_in,
    input  logic              sleep_deep,
    input  logic              pd_start,
    input  logic              rd_en,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data
);
    import sdm_pkg::*;

    logic               sd_prev;
    logic               sleep_rise;
    logic               slow_tick;
    logic               snap;
    logic [SLOW_W-1:0]  coarse;
    logic [FINE_W-1:0]  fine_live;
    logic [FINE_W-1:0]  fine_held;
    logic [ENTRY_W-1:0] entry_cnt;
    logic               entry_busy;
    logic [DATA_W-1:0]  rd_next;
    sdm_sel_e           sel;

    // Keep the previous deep-sleep level so its rising edge can be found.
    always_ff @(posedge clk) begin
        if (!rst_n) sd_prev <= 1'b0;
        else        sd_prev <= sleep_deep;
    end

    assign sleep_rise = sleep_deep & ~sd_prev;
    assign sel        = sdm_sel_e'(rd_sel);
    assign snap       = rd_en && (sel == SEL_COARSE);

    sdm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_in   (slow_clk_in),
        .rise_pulse (slow_tick)
    );

    sdm_coarse_fine #(.SLOW_W(SLOW_W), .FINE_W(FINE_W)) u_cf (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (slow_tick),
        .restart   (sleep_rise),
        .snap      (snap),
        .coarse    (coarse),
        .fine_live (fine_live),
        .fine_held (fine_held)
    );

    sdm_entry_lat #(.ENTRY_W(ENTRY_W)) u_entry (
        .clk   (clk),
        .rst_n (rst_n),
        .start (sleep_rise),
        .stop  (pd_start),
        .count (entry_cnt),
        .busy  (entry_busy)
    );

    // Select the value to read and zero-extend it to the data width.
    always_comb begin
        rd_next = '0;
        unique case (sel)
            SEL_COARSE: rd_next = DATA_W'(coarse);
            SEL_FINE:   rd_next = DATA_W'(fine_held);
            SEL_ENTRY:  rd_next = DATA_W'(entry_cnt);
            SEL_NONE:   rd_next = '0;
        endcase
    end

    // Register the read data. It is updated only when a read is requested.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_next;
    end
endmodule

// File: rtl/sdm_checker.sv
// Temporal checks on the sleep duration counters, attached to the top level by bind.
module sdm_checker #(
    parameter int SLOW_W  = 32,
    parameter int FINE_W  = 11,
    parameter int ENTRY_W = 16,
    parameter int DATA_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rd_en,
    input logic [1:0]         rd_sel,
    input logic [DATA_W-1:0]  rd_data,
    input logic               pd_start,
    input logic               sleep_rise,
    input logic               slow_tick,
    input logic [SLOW_W-1:0]  coarse,
    input logic [FINE_W-1:0]  fine_live,
    input logic [FINE_W-1:0]  fine_held,
    input logic [ENTRY_W-1:0] entry_cnt,
    input logic               entry_busy
);
    localparam logic [FINE_W-1:0]  FMAX = {FINE_W{1'b1}};
    localparam logic [ENTRY_W-1:0] EMAX = {ENTRY_W{1'b1}};

    AST_COARSE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_tick && !sleep_rise) |=> coarse == $past(coarse) + 1'b1); // R2
    AST_COARSE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_rise |=> coarse == '0); // R3
    AST_FINE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        slow_tick |=> fine_live == '0); // R4
    AST_FINE_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        (fine_live == FMAX && !slow_tick) |=> fine_live == FMAX); // R5
    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && rd_sel == 2'd0) |=> $stable(fine_held)); // R6
    AST_ENTRY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!entry_busy && !sleep_rise) |=> $stable(entry_cnt)); // R7
    AST_ENTRY_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_cnt == EMAX && !sleep_rise) |=> entry_cnt == EMAX); // R8
    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R9
    AST_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_start && !entry_busy && !sleep_rise) |=> $stable(entry_cnt) && !entry_busy); // R10
endmodule

bind sleep_timer_pair sdm_checker #(
    .SLOW_W(SLOW_W), .FINE_W(FINE_W), .ENTRY_W(ENTRY_W), .DATA_W(DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .rd_sel     (rd_sel),
    .rd_data    (rd_data),
    .pd_start   (pd_start),
    .sleep_rise (sleep_rise),
    .slow_tick  (slow_tick),
    .coarse     (coarse),
    .fine_live  (fine_live),
    .fine_held  (fine_held),
    .entry_cnt  (entry_cnt),
    .entry_busy (entry_busy)
);

// File: tb/sleep_timer_pair_bench.sv
// Bench for sleep_timer_pair. A behavioural model is compared with rd_data on every cycle.
module sleep_timer_pair_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_clk_in = 1'b0;
    logic        sleep_deep = 1'b0;
    logic        pd_start = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    bit slow_run = 1'b0;
    int slow_half = 8;
    int slow_ph = 0;
    bit done = 1'b0;

    // model state
    bit          hist[$];
    longint      m_coarse, m_fine, m_held, m_entry, m_rd;
    bit          m_busy, m_sdprev;
    string       m_tag = "R1";

    always #2.5 clk = ~clk;   // 200 MHz

    sleep_timer_pair u_sleep_timer_pair (
        .clk(clk), .rst_n(rst_n), .slow_clk_in(slow_clk_in), .sleep_deep(sleep_deep),
        .pd_start(pd_start), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    // Reference model, evaluated from the inputs present at each rising edge.
    always @(posedge clk) begin
        bit tick, rise;
        longint old_coarse, old_fine, old_held, old_entry;
        tick = (hist.size() >= 3) && hist[1] && !hist[2];
        rise = sleep_deep && !m_sdprev;
        old_coarse = m_coarse; old_fine = m_fine; old_held = m_held; old_entry = m_entry;
        if (!rst_n) begin
            hist.delete(); hist.push_front(1'b0); hist.push_front(1'b0); hist.push_front(1'b0);
            m_coarse = 0; m_fine = 0; m_held = 0; m_entry = 0; m_rd = 0;
            m_busy = 0; m_sdprev = 0; m_tag = "R1";
        end else begin
            hist.push_front(slow_clk_in);
            void'(hist.pop_back());
            if (rise) m_coarse = 0;
            else if (tick) m_coarse = (old_coarse + 1) % 64'h1_0000_0000;
            if (tick) m_fine = 0;
            else if (old_fine < 2047) m_fine = old_fine + 1;
            if (rd_en && rd_sel == 2'd0) m_held = old_fine;
            if (rise) begin m_entry = 0; m_busy = 1; end
            else if (m_busy) begin
                if (pd_start) m_busy = 0;
                else if (old_entry < 65535) m_entry = old_entry + 1;
            end
            if (rd_en) begin
                case (rd_sel)
                    2'd0: begin m_rd = old_coarse; m_tag = "R2"; end
                    2'd1: begin m_rd = old_held;   m_tag = "R6"; end
                    2'd2: begin m_rd = old_entry;  m_tag = "R7"; end
                    default: begin m_rd = 0;       m_tag = "R9"; end
                endcase
            end
            m_sdprev = sleep_deep;
        end
    end

    // Compare away from the active edge, and toggle the slow clock when enabled.
    always @(negedge clk) begin
        cycles++;
        if (!done) begin
            vectors++;
            if (rd_data !== m_rd[31:0]) begin
                errors++;
                $display("FAIL %s cycle %0d: rd_data actual %0d expected %0d", m_tag, cycles, rd_data, m_rd);
            end
        end
        if (slow_run) begin
            slow_ph++;
            if (slow_ph >= slow_half) begin slow_ph = 0; slow_clk_in = ~slow_clk_in; end
        end
        if (cycles > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] s);
        @(negedge clk); rd_en = 1'b1; rd_sel = s;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic pulse_pd();
        @(negedge clk); pd_start = 1'b1;
        @(negedge clk); pd_start = 1'b0;
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        // R1 and R9: reset values and the zero select
        rd(2'd0); rd(2'd1); rd(2'd2); rd(2'd3);
        // R2, R4: running slow clock, with coarse and fine reads
        slow_run = 1'b1;
        idle(60); rd(2'd0); rd(2'd1); idle(5); rd(2'd1);
        idle(37); rd(2'd0); idle(11); rd(2'd1); rd(2'd2);
        // R3, R7: sleep entry restarts the coarse count and starts the entry count
        @(negedge clk); sleep_deep = 1'b1;
        idle(3); rd(2'd0); idle(20); pulse_pd(); idle(9); rd(2'd2); rd(2'd0); rd(2'd1);
        // R10: a strobe with no measurement running changes nothing
        pulse_pd(); idle(4); rd(2'd2);
        // R3: a second entry while the slow clock runs
        @(negedge clk); sleep_deep = 1'b0; idle(13); sleep_deep = 1'b1;
        idle(7); rd(2'd0); rd(2'd2); pulse_pd(); rd(2'd2);
        // R5: slow clock stopped long enough for the fine count to saturate
        slow_run = 1'b0; slow_clk_in = 1'b0;
        idle(2100); rd(2'd0); rd(2'd1); rd(2'd1);
        // R4: first slow edge after the pause restarts the fine count
        @(negedge clk); slow_clk_in = 1'b1; idle(5); rd(2'd0); rd(2'd1);
        // R8: entry measurement without a strobe saturates
        @(negedge clk); sleep_deep = 1'b0; idle(2); sleep_deep = 1'b1;
        idle(65600); rd(2'd2); pulse_pd(); rd(2'd2); rd(2'd3);
        idle(4);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule